// File: doc/BRIEF.md
# Programmable interval counter channel

This block is a single 16-bit timer channel that counts down in binary. It has six waveform modes. A counter clock enable paces it. A gate input can pause counting or restart it, and a single output line carries the selected waveform. A register front end presents a new initial count and mode together, with a one-cycle load strobe. The channel continuously presents its current count value and output level, so the front end can latch them whenever it chooses.

Internally the channel tracks how many counter clocks have elapsed since the last restart. It keeps three pieces of state: a phase that runs modulo the loaded count, a saturating wrap tally, and a free-running 16-bit down counter. A combinational decoder derives the visible count and the output line from that state according to the mode. Host bus decoding, decimal counting and interrupt routing are left to the surrounding logic.

Top module: `ictr_channel`

## Requirements
- R1: After reset the channel is in mode 0 with a loaded count of 0 (meaning 65536), `count_view` reads 0 and `out_level` is low.
- R2: A cycle with `load_valid` high takes `load_mode` and `load_count`. From the next cycle the elapsed count is zero and `count_view` shows the loaded value. A load in the middle of a run restarts the sequence.
- R3: In modes 0 and 1, `out_level` is low while the elapsed count is below the loaded count N. It goes high when the elapsed count reaches N and then stays high.
- R4: In mode 2, `count_view` equals N minus (elapsed mod N). `out_level` is high exactly when the elapsed count is a non-zero multiple of N.
- R5: In mode 3, `out_level` is high while (elapsed mod N) < (N+1)/2 and low for the rest of the period, so an odd count has a high phase one clock longer. `count_view` equals N minus ((2 × elapsed) mod N), so it falls by two per clock.
- R6: In modes 4 and 5, `out_level` is high only while the elapsed count equals N, and the count is not reloaded.
- R7: In modes 0, 1, 4 and 5, `count_view` equals (N − elapsed) mod 65536, so it keeps decrementing past zero and wraps to 0xFFFF.
- R8: In modes 1, 2, 3 and 5, a rising edge on `gate` (low in one cycle, high in the next) restarts the elapsed count at zero. In modes 0 and 4 a gate edge does not restart counting.
- R9: In modes 0, 2, 3 and 4 the elapsed count does not advance while `gate` is low. In modes 1 and 5 it advances regardless of `gate`.
- R10: A `load_count` of 0 acts as a count of 65536.
- R11: The elapsed count advances by one only in a cycle with `cnt_en` high and no restart. Otherwise the outputs hold.
- R12: Mode code 6 behaves as mode 2, and mode code 7 behaves as mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter clock enable, one pulse per count |
| gate | input | 1 | Gate level; its rising edge can retrigger |
| load_valid | input | 1 | One-cycle strobe that applies mode and count |
| load_mode | input | 3 | Operating mode code 0..7 |
| load_count | input | 16 | Initial count; 0 means 65536 |
| count_view | output | 16 | Current visible count value |
| out_level | output | 1 | Channel output line |

## Verification
Two cases take thousands of counter clocks and cannot be forced from the ports: the full 65536 count and the 16-bit wrap of the visible value. The stimulus handles the wrap by loading a count of 2 and letting it run past zero. It handles 65536 by loading zero in mode 2 and letting it run through a whole period, so that the single indication at 65536 is seen. Gate retriggering relies on the sampled edge. The bench therefore drops `gate` for one cycle and raises it again in each mode, and separately holds it low while `cnt_en` toggles. The bench also loads a new count in the middle of a run, which shows that a load outranks both a gate edge and a tick.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5
    } tmr_mode_e;

    // codes 6 and 7 fold onto the rate and square modes (R12)
    function automatic tmr_mode_e norm_mode(input logic [2:0] code);
        case (code)
            3'd6:    norm_mode = MD_RATE;
            3'd7:    norm_mode = MD_SQUARE;
            default: norm_mode = tmr_mode_e'(code);
        endcase
    endfunction

endpackage

// File: rtl/ictr_ctrl.sv
module ictr_ctrl
    import ictr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             gate,
    input  logic             load_valid,
    input  logic [2:0]       load_mode,
    input  logic [CNT_W-1:0] load_count,
    output tmr_mode_e        mode_q,
    output logic [CNT_W:0]   span_q,
    output logic [CNT_W:0]   restart_span,
    output logic             restart,
    output logic             adv
);
    localparam int PH_W = CNT_W + 1;
    localparam logic [PH_W-1:0] FULL_SPAN = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        tmr_mode_e       mode;
        logic [PH_W-1:0] span;
        logic            gate;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic  rise, retrig, free_run;
    logic [PH_W-1:0] new_span;

    always_comb begin
        st_d      = st_q;
        st_d.gate = gate;
        rise      = gate & ~st_q.gate;
        new_span  = (load_count == '0) ? FULL_SPAN : {1'b0, load_count};
        retrig    = (st_q.mode == MD_ONESHOT) || (st_q.mode == MD_RATE) ||
                    (st_q.mode == MD_SQUARE)  || (st_q.mode == MD_HWSTB);
        free_run  = (st_q.mode == MD_ONESHOT) || (st_q.mode == MD_HWSTB);
        restart   = load_valid | (rise & retrig);
        adv       = ~restart & cnt_en & (gate | free_run);
        restart_span = load_valid ? new_span : st_q.span;
        if (load_valid) begin
            st_d.mode = norm_mode(load_mode);
            st_d.span = new_span;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MD_TERM;
            st_q.span <= FULL_SPAN;
            st_q.gate <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
    assign span_q = st_q.span;

    // R9: gated modes never advance with the gate low
    p_gate_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MD_TERM || st_q.mode == MD_RATE ||
          st_q.mode == MD_SQUARE || st_q.mode == MD_SWSTB) && !gate) |-> !adv);

    // R10: a zero count is stored as the full 2^CNT_W span
    p_zero_span_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_count == '0) |=> (span_q == FULL_SPAN));

endmodule

// File: rtl/ictr_phase.sv
module ictr_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W:0]   restart_span,
    input  logic             adv,
    input  logic [CNT_W:0]   span,
    output logic [CNT_W:0]   phase,
    output logic [1:0]       wraps,
    output logic [CNT_W-1:0] down
);
    localparam int PH_W = CNT_W + 1;
    localparam logic [PH_W-1:0] ONE_P = 1;
    localparam logic [CNT_W-1:0] ONE_C = 1;
    localparam logic [1:0] WRAP_SAT = 2'd2;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [1:0]       wraps;
        logic [CNT_W-1:0] down;
    } ph_s;

    ph_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.phase = '0;
            st_d.wraps = '0;
            st_d.down  = restart_span[CNT_W-1:0];
        end else if (adv) begin
            st_d.down = st_q.down - ONE_C;
            if (st_q.phase == span - ONE_P) begin
                st_d.phase = '0;
                if (st_q.wraps != WRAP_SAT) st_d.wraps = st_q.wraps + 2'd1;
            end else begin
                st_d.phase = st_q.phase + ONE_P;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.wraps <= '0;
            st_q.down  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign wraps = st_q.wraps;
    assign down  = st_q.down;

    // R4: phase always stays inside the current period
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase < span);

    // R11: without a tick or restart the state holds
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !adv) |=> $stable(st_q));

    // R2: a restart clears the elapsed position
    p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0 && wraps == 2'd0));

endmodule

// File: rtl/ictr_wave.sv
module ictr_wave
    import ictr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  tmr_mode_e        mode,
    input  logic [CNT_W:0]   span,
    input  logic [CNT_W:0]   phase,
    input  logic [1:0]       wraps,
    input  logic [CNT_W-1:0] down,
    output logic [CNT_W-1:0] count_view,
    output logic             out_level
);
    localparam int PH_W = CNT_W + 1;
    localparam logic [PH_W:0] ONE_X = 1;

    logic [PH_W:0]   twice, span_x, fold, half;
    logic [PH_W-1:0] rate_cnt, sq_cnt;

    always_comb begin
        twice    = {phase, 1'b0};
        span_x   = {1'b0, span};
        fold     = (twice >= span_x) ? (twice - span_x) : twice;
        half     = (span_x + ONE_X) >> 1;
        rate_cnt = span - phase;
        sq_cnt   = span - fold[PH_W-1:0];
        case (mode)
            MD_RATE: begin
                count_view = rate_cnt[CNT_W-1:0];
                out_level  = (phase == '0) && (wraps != 2'd0);
            end
            MD_SQUARE: begin
                count_view = sq_cnt[CNT_W-1:0];
                out_level  = ({1'b0, phase} < half);
            end
            MD_SWSTB, MD_HWSTB: begin
                count_view = down;
                out_level  = (phase == '0) && (wraps == 2'd1);
            end
            default: begin
                count_view = down;
                out_level  = (wraps != 2'd0);
            end
        endcase
    end

endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
    import ictr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             gate,
    input  logic             load_valid,
    input  logic [2:0]       load_mode,
    input  logic [CNT_W-1:0] load_count,
    output logic [CNT_W-1:0] count_view,
    output logic             out_level
);
    localparam int PH_W = CNT_W + 1;

    tmr_mode_e        mode_q;
    logic [PH_W-1:0]  span_q, restart_span, phase;
    logic             restart, adv;
    logic [1:0]       wraps;
    logic [CNT_W-1:0] down;

    ictr_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
        .load_valid(load_valid), .load_mode(load_mode), .load_count(load_count),
        .mode_q(mode_q), .span_q(span_q), .restart_span(restart_span),
        .restart(restart), .adv(adv)
    );

    ictr_phase #(.CNT_W(CNT_W)) phase_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .restart_span(restart_span),
        .adv(adv), .span(span_q), .phase(phase), .wraps(wraps), .down(down)
    );

    ictr_wave #(.CNT_W(CNT_W)) wave_i (
        .mode(mode_q), .span(span_q), .phase(phase), .wraps(wraps), .down(down),
        .count_view(count_view), .out_level(out_level)
    );

    // R3: once high in modes 0/1 the output stays high until a restart
    p_sticky_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_TERM || mode_q == MD_ONESHOT) && out_level && !restart)
        |=> out_level);

    // R6: a strobe ends on the next counter tick
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_SWSTB || mode_q == MD_HWSTB) && out_level && adv)
        |=> !out_level);

    // R7: in the plain counting modes one tick lowers the visible count by one
    p_wrap_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_TERM || mode_q == MD_ONESHOT) && adv)
        |=> (count_view == $past(count_view) - 16'd1));

endmodule

// File: tb/ictr_channel_tb_top.sv
module ictr_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        gate = 1'b0;
    logic        load_valid = 1'b0;
    logic [2:0]  load_mode = 3'd0;
    logic [15:0] load_count = 16'd0;
    logic [15:0] count_view;
    logic        out_level;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    longint m_d, m_n;
    int     m_mode;
    bit     m_gprev;

    always #10 clk = ~clk;

    ictr_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
        .load_valid(load_valid), .load_mode(load_mode), .load_count(load_count),
        .count_view(count_view), .out_level(out_level)
    );

    function automatic longint exp_count();
        case (m_mode)
            2:       return (m_n - (m_d % m_n)) & 16'hFFFF;
            3:       return (m_n - ((2 * m_d) % m_n)) & 16'hFFFF;
            default: return (m_n - m_d) & 16'hFFFF;
        endcase
    endfunction

    function automatic bit exp_out();
        case (m_mode)
            0, 1:    return m_d >= m_n;
            2:       return (m_d != 0) && ((m_d % m_n) == 0);
            3:       return (m_d % m_n) < ((m_n + 1) / 2);
            default: return m_d == m_n;
        endcase
    endfunction

    task automatic compare();
        longint ec;
        bit eo;
        ec = exp_count();
        eo = exp_out();
        checks++;
        if (count_view !== ec[15:0] || out_level !== eo) begin
            errors++;
            $display("FAIL %s mode=%0d d=%0d count=%h/%h out=%b/%b (actual/expected)",
                     tag, m_mode, m_d, count_view, ec[15:0], out_level, eo);
        end
    endtask

    // apply current inputs for one edge, update the model, compare afterwards
    task automatic step();
        bit rise, retrig, free;
        rise   = gate && !m_gprev;
        retrig = (m_mode == 1) || (m_mode == 2) || (m_mode == 3) || (m_mode == 5);
        free   = (m_mode == 1) || (m_mode == 5);
        if (load_valid) begin
            m_mode = (load_mode >= 6) ? int'(load_mode) - 4 : int'(load_mode);
            m_n    = (load_count == 0) ? 65536 : longint'(load_count);
            m_d    = 0;
        end else if (rise && retrig) begin
            m_d = 0;
        end else if (cnt_en && (gate || free)) begin
            m_d++;
        end
        m_gprev = gate;
        @(posedge clk);
        @(negedge clk);
        load_valid = 1'b0;
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load(input logic [2:0] md, input logic [15:0] cnt);
        load_valid = 1'b1;
        load_mode  = md;
        load_count = cnt;
        step();
    endtask

    task automatic gate_pulse(input int low_cycles);
        gate = 1'b0;
        run(low_cycles);
        gate = 1'b1;
        run(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired tag=%s", tag);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int hi;
        m_mode = 0; m_n = 65536; m_d = 0; m_gprev = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        compare();                       // reset state, R1

        gate = 1'b1; cnt_en = 1'b1;
        tag = "R3"; load(3'd0, 16'd5); run(10);
        tag = "R11";
        for (int i = 0; i < 12; i++) begin cnt_en = i[0]; step(); end
        cnt_en = 1'b1;
        tag = "R9"; load(3'd0, 16'd6); gate = 1'b0; run(4); gate = 1'b1; run(6);
        tag = "R8"; load(3'd0, 16'd4); run(2); gate_pulse(1); run(4);

        tag = "R3"; load(3'd1, 16'd4); run(6);
        tag = "R8"; gate_pulse(2); run(5);
        tag = "R9"; load(3'd1, 16'd5); gate = 1'b0; run(7); gate = 1'b1; run(2);

        tag = "R4"; load(3'd2, 16'd3); run(12);
        tag = "R8"; run(1); gate_pulse(1); run(5);
        tag = "R9"; gate = 1'b0; run(3); gate = 1'b1; run(4);

        tag = "R5"; load(3'd3, 16'd5);
        hi = int'(out_level);
        for (int i = 0; i < 4; i++) begin step(); hi += int'(out_level); end
        checks++;
        if (hi != 3) begin
            errors++;
            $display("FAIL R5 odd high phase length actual=%0d expected=3", hi);
        end
        run(12);
        load(3'd3, 16'd4); run(10);
        tag = "R8"; gate_pulse(1); run(4);

        tag = "R6"; load(3'd4, 16'd3); run(8);
        tag = "R8"; load(3'd4, 16'd5); run(2); gate_pulse(1); run(6);
        tag = "R6"; load(3'd5, 16'd3); run(6);
        tag = "R8"; gate_pulse(1); run(5);

        tag = "R7"; load(3'd0, 16'd2); run(5);
        load(3'd5, 16'd1); run(4);

        tag = "R2"; load(3'd2, 16'd9); run(4); load(3'd0, 16'd300); run(3);
        gate = 1'b0; run(1); gate = 1'b1; load(3'd3, 16'd7); run(4);

        tag = "R12"; load(3'd6, 16'd3); run(8); load(3'd7, 16'd5); run(8);

        tag = "R10"; load(3'd2, 16'd0); run(65540);

        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            gate   = ($urandom_range(0, 5) != 0);
            cnt_en = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 60) == 0) begin
                load_valid = 1'b1;
                load_mode  = 3'($urandom_range(0, 7));
                load_count = 16'($urandom_range(0, 9));
            end
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule